// File: doc/BRIEF.md
# Multi-Mode IQ Sample Receive Buffer

This block sits on the receive side of a serial radio link, between the deframer and an application. It holds a small queue of 32-bit IQ samples. Each sample is packed with the in-phase half in the low 16 bits and the quadrature half in the high 16 bits. The application takes samples out under one of three read disciplines. The discipline is chosen by a 2-bit mode input, which is captured only while the synchronous reset is high.

In handshake mode the application raises `rd_ready` one cycle ahead of each transfer. The buffer then presents a sample whenever its fill level is strictly above a shared threshold. In resync mode a single `resync` pulse starts a free-running stream of one sample per cycle. In self-start mode the buffer raises `start_pulse` once, the first time the fill level passes the threshold, and streams one sample per cycle from the cycle after that. Writes into a full queue are dropped. A free-running read of an empty queue repeats the last delivered sample. Each of these two events sets its own sticky flag.

Top module: `iq_rx_buffer`

## Requirements
- R1: `rd_data` carries the in-phase half in bits [15:0] and the quadrature half in bits [31:16], and samples leave in the order they were written.
- R2: In handshake mode (`mode_sel` = 00), `rd_valid` is high in cycle N+1 only if `rd_ready` was high in cycle N and the fill level exceeds `fill_thr`. Each cycle with `rd_valid` high removes exactly one sample at the end of that cycle.
- R3: The threshold comparison is strictly greater-than. With `fill_thr` = 0 one stored sample is enough for `rd_valid`. With `fill_thr` = 1 a single stored sample is not enough.
- R4: In resync mode (`mode_sel` = 01), a `resync` pulse in cycle N makes `rd_valid` high from cycle N+1, showing the oldest sample. One sample is removed per cycle after that, and `rd_ready` has no effect.
- R5: A `resync` given while the queue is still empty is accepted. The stream starts at once and returns the last delivered value, which is zero after reset.
- R6: In self-start mode (`mode_sel` = 10), `start_pulse` is high for exactly one cycle: the cycle after the fill level first exceeds `fill_thr` following reset. It does not recur. `rd_ready` and `resync` have no effect in this mode.
- R7: In self-start mode, `rd_valid` rises in the cycle after `start_pulse`, showing the oldest sample. One sample is removed per cycle from then on.
- R8: A write while the fill level equals the depth (16) is dropped, so the level and the stored samples are unchanged. `overflow` rises in the next cycle and stays high until reset.
- R9: In a free-running mode, a read cycle with an empty queue keeps `rd_data` at the last delivered sample. `underflow` rises in the next cycle and stays high until reset.
- R10: `mode_sel` is sampled only while `rst` is high. Changing it afterwards has no effect, and a `resync` in handshake mode is ignored.
- R11: While `rst` is high, the queue empties, and `rd_valid`, `start_pulse`, `overflow` and `underflow` are low, with `fill_level` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both write and read sides |
| rst | input | 1 | Synchronous reset, active high; also captures `mode_sel` |
| mode_sel | input | 2 | Read discipline: 00 handshake, 01 resync, 10 self-start, 11 treated as handshake |
| fill_thr | input | 5 | Shared fill threshold, compared strictly greater-than |
| wr_en | input | 1 | Write strobe from the deframer |
| wr_i | input | 16 | In-phase half of the incoming sample |
| wr_q | input | 16 | Quadrature half of the incoming sample |
| rd_ready | input | 1 | Application ready, one cycle ahead of the transfer (handshake mode only) |
| resync | input | 1 | Stream start pulse (resync mode only) |
| rd_data | output | 32 | Sample presented to the application |
| rd_valid | output | 1 | Sample qualifier / stream active |
| start_pulse | output | 1 | One-cycle start indication in self-start mode |
| fill_level | output | 5 | Number of stored samples |
| overflow | output | 1 | Sticky: a write was dropped |
| underflow | output | 1 | Sticky: a free-running read found the queue empty |

## Verification
If a pointer goes wrong, the fault shows on `rd_data` in the first valid cycle after it: a sample arrives out of order or is repeated. A bad count appears on `fill_level` at once. It also shifts the cycle in which `rd_valid` or `start_pulse` rises by one or more cycles, which is why every check lands on an exact cycle. A latched-mode error shows as `rd_valid` reacting to the handshake or stream input of another mode within one cycle. Lost stickiness shows as a flag that drops a cycle after it rose.

// File: rtl/iq_rx_pkg.sv
package iq_rx_pkg;

    typedef enum logic [1:0] {
        MODE_HSK  = 2'b00,
        MODE_SYNC = 2'b01,
        MODE_SELF = 2'b10,
        MODE_RSVD = 2'b11
    } rx_mode_e;

    typedef struct packed {
        logic [15:0] q;
        logic [15:0] i;
    } iq_sample_t;

endpackage

// File: rtl/iq_rx_store.sv
module iq_rx_store #(
    parameter int DEPTH = 16,
    parameter int W     = 32,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  logic [W-1:0]     wdata,
    output logic [W-1:0]     head,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);

    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] rptr;
        logic [CNT_W-1:0] cnt;
    } store_t;

    store_t st_d, st_q;
    logic [W-1:0] mem [DEPTH];
    logic push_ok, pop_ok;

    always_comb begin
        full    = (st_q.cnt == FULL_CNT);
        empty   = (st_q.cnt == '0);
        push_ok = push && !full;
        pop_ok  = pop && !empty;
        st_d    = st_q;
        if (push_ok) begin
            st_d.wptr = (st_q.wptr == LAST_IDX) ? '0 : st_q.wptr + 1'b1;
        end
        if (pop_ok) begin
            st_d.rptr = (st_q.rptr == LAST_IDX) ? '0 : st_q.rptr + 1'b1;
        end
        case ({push_ok, pop_ok})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
        if (rst) begin
            st_d = '0;
        end
        head  = mem[st_q.rptr];
        count = st_q.cnt;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok && !rst) begin
            mem[st_q.wptr] <= wdata;
        end
    end

    // R8
    full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> (count == $past(count)));

endmodule

// File: rtl/iq_rx_read_ctrl.sv
module iq_rx_read_ctrl
    import iq_rx_pkg::*;
#(
    parameter int W     = 32,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode_sel,
    input  logic             rd_ready,
    input  logic             resync,
    input  logic [CNT_W-1:0] fill,
    input  logic [CNT_W-1:0] thr,
    input  logic             empty,
    input  logic [W-1:0]     head,
    output logic             pop,
    output logic             rd_valid,
    output logic [W-1:0]     rd_data,
    output logic             start_pulse,
    output logic             underrun
);

    typedef struct packed {
        rx_mode_e     mode;
        logic         ready;
        logic         running;
        logic         started;
        logic         start;
        logic [W-1:0] last;
    } rctl_t;

    rctl_t st_d, st_q;
    logic  hsk_like;
    logic  above;

    always_comb begin
        hsk_like = (st_q.mode == MODE_HSK) || (st_q.mode == MODE_RSVD);
        above    = (fill > thr);
        if (hsk_like) begin
            rd_valid = st_q.ready && above;
            pop      = st_q.ready && above;
        end else begin
            rd_valid = st_q.running;
            pop      = st_q.running;
        end
        rd_data     = empty ? st_q.last : head;
        underrun    = !hsk_like && st_q.running && empty;
        start_pulse = st_q.start;

        st_d       = st_q;
        st_d.ready = hsk_like && rd_ready;
        st_d.start = 1'b0;
        case (st_q.mode)
            MODE_SYNC: st_d.running = st_q.running || resync;
            MODE_SELF: begin
                st_d.start   = !st_q.started && above;
                st_d.started = st_q.started || (!st_q.started && above);
                st_d.running = st_q.running || st_q.start;
            end
            default:   st_d.running = 1'b0;
        endcase
        if (pop && !empty) begin
            st_d.last = head;
        end
        if (rst) begin
            st_d      = '0;
            st_d.mode = rx_mode_e'(mode_sel);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // R2
    ready_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.mode == MODE_HSK && rd_valid) |-> $past(rd_ready));

    // R4
    resync_to_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.mode == MODE_SYNC && resync) |=> rd_valid);

    // R6
    start_single_chk: assert property (@(posedge clk) disable iff (rst)
        start_pulse |=> !start_pulse);

    // R7
    valid_after_start_chk: assert property (@(posedge clk) disable iff (rst)
        start_pulse |=> rd_valid);

endmodule

// File: rtl/iq_rx_flags.sv
module iq_rx_flags (
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic full,
    input  logic underrun,
    output logic overflow,
    output logic underflow
);

    typedef struct packed {
        logic ovf;
        logic unf;
    } flag_t;

    flag_t st_d, st_q;

    always_comb begin
        st_d.ovf = st_q.ovf || (wr_en && full);
        st_d.unf = st_q.unf || underrun;
        if (rst) begin
            st_d = '0;
        end
        overflow  = st_q.ovf;
        underflow = st_q.unf;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    // R9
    unf_set_chk: assert property (@(posedge clk) disable iff (rst)
        underrun |=> underflow);

endmodule

// File: rtl/iq_rx_buffer.sv
module iq_rx_buffer
    import iq_rx_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode_sel,
    input  logic [CNT_W-1:0] fill_thr,
    input  logic             wr_en,
    input  logic [15:0]      wr_i,
    input  logic [15:0]      wr_q,
    input  logic             rd_ready,
    input  logic             resync,
    output logic [31:0]      rd_data,
    output logic             rd_valid,
    output logic             start_pulse,
    output logic [CNT_W-1:0] fill_level,
    output logic             overflow,
    output logic             underflow
);

    localparam int W = $bits(iq_sample_t);

    iq_sample_t       wsample;
    logic [W-1:0]     head;
    logic [CNT_W-1:0] count;
    logic             full, empty, pop, underrun;

    always_comb begin
        wsample.i  = wr_i;
        wsample.q  = wr_q;
        fill_level = count;
    end

    iq_rx_store #(.DEPTH(DEPTH), .W(W)) u_store (
        .clk   (clk),
        .rst   (rst),
        .push  (wr_en),
        .pop   (pop),
        .wdata (wsample),
        .head  (head),
        .count (count),
        .full  (full),
        .empty (empty)
    );

    iq_rx_read_ctrl #(.W(W), .CNT_W(CNT_W)) u_rctl (
        .clk         (clk),
        .rst         (rst),
        .mode_sel    (mode_sel),
        .rd_ready    (rd_ready),
        .resync      (resync),
        .fill        (count),
        .thr         (fill_thr),
        .empty       (empty),
        .head        (head),
        .pop         (pop),
        .rd_valid    (rd_valid),
        .rd_data     (rd_data),
        .start_pulse (start_pulse),
        .underrun    (underrun)
    );

    iq_rx_flags u_flags (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .full      (full),
        .underrun  (underrun),
        .overflow  (overflow),
        .underflow (underflow)
    );

endmodule

// File: tb/iq_rx_buffer_bench.sv
module iq_rx_buffer_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode_sel = 2'b00;
    logic [4:0]  fill_thr = '0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_i = '0;
    logic [15:0] wr_q = '0;
    logic        rd_ready = 1'b0;
    logic        resync = 1'b0;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic        start_pulse;
    logic [4:0]  fill_level;
    logic        overflow;
    logic        underflow;

    int checks = 0;
    int errors = 0;

    iq_rx_buffer u_iq_rx_buffer (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .fill_thr(fill_thr),
        .wr_en(wr_en), .wr_i(wr_i), .wr_q(wr_q), .rd_ready(rd_ready),
        .resync(resync), .rd_data(rd_data), .rd_valid(rd_valid),
        .start_pulse(start_pulse), .fill_level(fill_level),
        .overflow(overflow), .underflow(underflow)
    );

    always #10 clk = ~clk;

    typedef struct packed {
        logic       wr;
        logic [7:0] kw;
        logic       rdy;
        logic       ev;
        logic [7:0] kd;
        logic [4:0] ef;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{1'b1, 8'd0, 1'b0, 1'b0, 8'd0, 5'd1},
        '{1'b1, 8'd1, 1'b1, 1'b0, 8'd0, 5'd2},
        '{1'b1, 8'd2, 1'b1, 1'b1, 8'd0, 5'd3},
        '{1'b0, 8'd0, 1'b1, 1'b0, 8'd1, 5'd2},
        '{1'b1, 8'd3, 1'b0, 1'b0, 8'd1, 5'd3},
        '{1'b0, 8'd0, 1'b1, 1'b1, 8'd1, 5'd3},
        '{1'b1, 8'd4, 1'b1, 1'b1, 8'd2, 5'd3},
        '{1'b1, 8'd5, 1'b0, 1'b0, 8'd3, 5'd3},
        '{1'b0, 8'd0, 1'b0, 1'b0, 8'd3, 5'd3}
    };

    function automatic logic [31:0] samp(input int k);
        logic [15:0] iv, qv;
        iv = 16'h1100 + 16'(k);
        qv = 16'h2200 + 16'(k);
        return {qv, iv};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put(input int k);
        logic [31:0] s;
        s     = samp(k);
        wr_en = 1'b1;
        wr_i  = s[15:0];
        wr_q  = s[31:16];
    endtask

    task automatic idle();
        wr_en    = 1'b0;
        rd_ready = 1'b0;
        resync   = 1'b0;
    endtask

    task automatic do_reset(input logic [1:0] m, input logic [4:0] t);
        @(negedge clk);
        rst      = 1'b1;
        mode_sel = m;
        fill_thr = t;
        idle();
        repeat (2) @(negedge clk);
        chk("R11 fill", 32'(fill_level), 32'd0);
        chk("R11 valid", 32'(rd_valid), 32'd0);
        chk("R11 start", 32'(start_pulse), 32'd0);
        chk("R11 flags", {30'd0, overflow, underflow}, 32'd0);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #4000000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        // Table: handshake mode, threshold 2 (R1, R2)
        do_reset(2'b00, 5'd2);
        for (int v = 0; v < 9; v++) begin
            if (VECS[v].wr) put(int'(VECS[v].kw));
            else wr_en = 1'b0;
            rd_ready = VECS[v].rdy;
            @(negedge clk);
            chk("R2 valid", 32'(rd_valid), 32'(VECS[v].ev));
            chk("R2 fill", 32'(fill_level), 32'(VECS[v].ef));
            chk("R1 data", rd_data, samp(int'(VECS[v].kd)));
        end
        idle();

        // R3: threshold 0, one sample suffices
        do_reset(2'b00, 5'd0);
        put(8'h40); rd_ready = 1'b1;
        @(negedge clk);
        idle();
        chk("R3 thr0 valid", 32'(rd_valid), 32'd1);
        chk("R3 thr0 data", rd_data, samp(8'h40));

        // R3: threshold 1, one sample is not enough
        do_reset(2'b00, 5'd1);
        put(8'h41); rd_ready = 1'b1;
        @(negedge clk);
        chk("R3 thr1 one", 32'(rd_valid), 32'd0);
        put(8'h42);
        @(negedge clk);
        idle();
        chk("R3 thr1 two", 32'(rd_valid), 32'd1);

        // R10: late mode change and resync in handshake mode are ignored
        do_reset(2'b00, 5'd0);
        mode_sel = 2'b01;
        resync = 1'b1; put(8'h43);
        @(negedge clk);
        idle();
        chk("R10 valid", 32'(rd_valid), 32'd0);
        @(negedge clk);
        chk("R10 still", 32'(rd_valid), 32'd0);
        chk("R10 fill", 32'(fill_level), 32'd1);

        // R4 / R9: resync mode with ready held low
        do_reset(2'b01, 5'd2);
        for (int k = 0; k < 3; k++) begin
            put(8'h50 + k);
            @(negedge clk);
        end
        idle();
        chk("R4 no valid before resync", 32'(rd_valid), 32'd0);
        chk("R4 fill", 32'(fill_level), 32'd3);
        resync = 1'b1;
        @(negedge clk);
        resync = 1'b0;
        chk("R4 valid", 32'(rd_valid), 32'd1);
        chk("R4 first", rd_data, samp(8'h50));
        @(negedge clk);
        chk("R4 second", rd_data, samp(8'h51));
        chk("R4 fill2", 32'(fill_level), 32'd2);
        @(negedge clk);
        chk("R4 third", rd_data, samp(8'h52));
        @(negedge clk);
        chk("R9 fill0", 32'(fill_level), 32'd0);
        chk("R9 repeat", rd_data, samp(8'h52));
        chk("R9 not yet", 32'(underflow), 32'd0);
        @(negedge clk);
        chk("R9 flag", 32'(underflow), 32'd1);
        chk("R9 repeat2", rd_data, samp(8'h52));
        @(negedge clk);
        chk("R9 sticky", 32'(underflow), 32'd1);

        // R5: early resync on an empty queue
        do_reset(2'b01, 5'd2);
        resync = 1'b1;
        @(negedge clk);
        resync = 1'b0;
        chk("R5 valid", 32'(rd_valid), 32'd1);
        chk("R5 data", rd_data, 32'd0);
        @(negedge clk);
        chk("R5 underflow", 32'(underflow), 32'd1);

        // R6 / R7: self-start mode, ready and resync held high
        do_reset(2'b10, 5'd2);
        rd_ready = 1'b1;
        for (int k = 0; k < 3; k++) begin
            put(8'h60 + k);
            resync = 1'b1;
            @(negedge clk);
        end
        wr_en = 1'b0;
        chk("R6 no start yet", 32'(start_pulse), 32'd0);
        chk("R6 ready ignored", 32'(rd_valid), 32'd0);
        @(negedge clk);
        chk("R6 start", 32'(start_pulse), 32'd1);
        chk("R7 not yet", 32'(rd_valid), 32'd0);
        @(negedge clk);
        chk("R6 one cycle", 32'(start_pulse), 32'd0);
        chk("R7 valid", 32'(rd_valid), 32'd1);
        chk("R7 first", rd_data, samp(8'h60));
        chk("R7 fill", 32'(fill_level), 32'd3);
        @(negedge clk);
        chk("R7 second", rd_data, samp(8'h61));
        chk("R7 fill2", 32'(fill_level), 32'd2);
        begin
            int pulses = 0;
            for (int k = 0; k < 6; k++) begin
                put(8'h68 + k);
                @(negedge clk);
                if (start_pulse) pulses++;
            end
            chk("R6 no repeat", 32'(pulses), 32'd0);
        end
        idle();

        // R8: overflow in handshake mode
        do_reset(2'b00, 5'd15);
        for (int k = 0; k < 16; k++) begin
            put(8'h70 + k);
            @(negedge clk);
        end
        chk("R8 full", 32'(fill_level), 32'd16);
        chk("R8 clean", 32'(overflow), 32'd0);
        put(8'h90);
        @(negedge clk);
        wr_en = 1'b0;
        chk("R8 fill held", 32'(fill_level), 32'd16);
        chk("R8 flag", 32'(overflow), 32'd1);
        rd_ready = 1'b1;
        @(negedge clk);
        rd_ready = 1'b0;
        chk("R8 valid", 32'(rd_valid), 32'd1);
        chk("R8 oldest", rd_data, samp(8'h70));
        @(negedge clk);
        chk("R8 after pop", 32'(fill_level), 32'd15);
        chk("R8 order", rd_data, samp(8'h71));
        chk("R8 sticky", 32'(overflow), 32'd1);

        // R11: reset clears the sticky flag
        do_reset(2'b00, 5'd0);

        finish_run();
    end

endmodule